// File: doc/BRIEF.md
# Display Controller Identification Sequencer

This block brings an unknown display controller, attached through an 8-bit parallel bus, out of reset and reads back the registers that identify it. One pulse on `start` runs the whole probe. The controller's reset pin goes through three timed phases (released, asserted, released). A soft-reset command then wakes the part, since some controllers ignore reads until they have received it. After that the block walks a fixed list of identification registers. For each one it writes the register address as a command byte and then reads a set number of response bytes.

Every byte that comes back is stored in a 27-entry result buffer in the order it arrives. Software or another block can read any entry through a small address/data port. When the list is finished, `done` rises. A signature comparator then checks a 3-byte programmable pattern against two places in the buffer: the second to fourth bytes of the first register, and the three single-byte registers. When both agree, `match` is raised.

Bus timing is deliberately simple. Every strobe is low for exactly one clock cycle and is followed by one recovery cycle.

Top module: `panel_id_probe`

## Requirements
- R1: After `rstN` is released, and before any start: `panelRstN`, `wrN` and `rdN` are high, and `busy`, `done` and `match` are low.
- R2: A start runs the controller reset in three phases: `panelRstN` high, then low, then high again. Each phase lasts `RESET_MS * CYC_PER_MS` clock cycles.
- R3: The first bus transaction after the reset phases is a command write of byte 0x01 with `dcSel` low. No read strobe occurs before it.
- R4: Register queries are issued in this order, with these byte counts: 0x04 (6), 0xA1 (6), 0xBF (6), 0xDA (1), 0xDB (1), 0xDC (1), 0xD3 (6). Each query is one write with `dcSel` low (command), followed by its reads with `dcSel` high (data). The bus carries no data-phase writes.
- R5: The block drives `dataBus` only during a command write and the recovery cycle after it. Whenever `rdN` is low, the bus is released to high impedance.
- R6: `wrN` and `rdN` are never low together. Each strobe pulse is low for exactly one cycle and is followed by at least one high cycle.
- R7: Response bytes are stored in buffer index order: query 0 at indices 0 to 5, query 1 at 6 to 11, query 2 at 12 to 17, 0xDA at 18, 0xDB at 19, 0xDC at 20, and query 6 at 21 to 26. `bufData` shows the entry selected by `bufAddr` in the same cycle.
- R8: `busy` is high for exactly `3*RESET_MS*CYC_PER_MS + 70` cycles per run. `done` is set when the last read completes and cleared by the next accepted start. `done` and `busy` are never both high.
- R9: `match` is high only while `done` is high, and only when both comparisons hold. The first is: buffer entries 1, 2 and 3 equal `sigBytes[23:16]`, `[15:8]` and `[7:0]`. The second is: entries 18, 19 and 20 equal the same three bytes. A change of `sigBytes` takes effect in the same cycle.
- R10: A start pulse while `busy` is high is ignored. The run keeps its length, command sequence and results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the sequencer |
| start | input | 1 | One-cycle pulse that begins a probe while idle |
| sigBytes | input | 24 | Expected identification bytes, first byte in bits 23:16 |
| bufAddr | input | 5 | Result buffer read index |
| bufData | output | 8 | Result buffer entry at `bufAddr` |
| panelRstN | output | 1 | Active-low reset to the display controller |
| dcSel | output | 1 | Low for command bytes, high for data bytes |
| wrN | output | 1 | Active-low write strobe |
| rdN | output | 1 | Active-low read strobe |
| dataBus | inout | 8 | Bidirectional data bus to the controller |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished; results and `match` are valid |
| match | output | 1 | Signature found at both positions |

## Verification
The bench uses a behavioural display model. It answers reads only after the soft-reset command, and it returns per-register bytes keyed to the last command written. With this model the bench runs four patterns:
- A device whose identification bytes agree at both places. This shows the full sequence, the timing and the buffer layout.
- The same results against a signature changed by one bit. This shows the comparator actually reads `sigBytes`.
- A device whose single-byte register disagrees in one bit while the 6-byte register still matches. This separates a design that checks only one of the two positions.
- A run with a stray start pulse in the middle. This separates a sequencer that restarts from one that ignores the pulse.

// File: rtl/probe_pkg.sv
package probe_pkg;

  localparam int NUM_QUERY = 7;
  localparam logic [7:0] SOFT_RESET_CMD = 8'h01;

  // Register address for each query slot (order matters: it sets buffer layout).
  function automatic logic [7:0] queryAddr(input int i);
    case (i)
      0:       return 8'h04;
      1:       return 8'hA1;
      2:       return 8'hBF;
      3:       return 8'hDA;
      4:       return 8'hDB;
      5:       return 8'hDC;
      default: return 8'hD3;
    endcase
  endfunction

  // Number of response bytes read back for each query slot.
  function automatic int queryLen(input int i);
    case (i)
      3, 4, 5: return 1;
      default: return 6;
    endcase
  endfunction

  // Buffer index of the first byte of a query slot.
  function automatic int queryOffset(input int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += queryLen(j);
    return s;
  endfunction

  localparam int NUM_BYTES = queryOffset(NUM_QUERY);
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int SIG_LEN   = 3;
  localparam int SIG_OFS_A = queryOffset(0) + 1;
  localparam int SIG_OFS_B = queryOffset(3);

  typedef struct packed {
    logic rstLow;    // hold controller reset
    logic dataSel;   // 1 = data phase, 0 = command phase
    logic wrStb;     // write strobe active
    logic rdStb;     // read strobe active
    logic busDrive;  // enable bus driver
    logic capture;   // store bus byte into buffer
    logic clear;     // new run accepted
    logic finish;    // last read completed
  } probe_ctl_t;

endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
#(
  parameter int PHASE_CYC = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output probe_ctl_t       ctl,
  output logic [7:0]       wrByte,
  output logic [IDX_W-1:0] capIdx,
  output logic             busy
);

  localparam int DLY_W = $clog2(PHASE_CYC + 1);
  localparam int QI_W  = $clog2(NUM_QUERY);
  localparam int BC_W  = $clog2(NUM_BYTES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_HI, S_RST_LO, S_RST_REL, S_SWR_WR, S_SWR_GAP,
    S_CMD_WR, S_CMD_GAP, S_RD, S_RD_GAP
  } state_t;

  state_t          state;
  logic [DLY_W-1:0] dlyCnt;
  logic [QI_W-1:0]  qIdx;
  logic [BC_W-1:0]  bCnt;
  logic             phaseEnd, lastByte, lastQuery;

  assign phaseEnd  = (dlyCnt == DLY_W'(PHASE_CYC - 1));
  assign lastByte  = (bCnt == BC_W'(queryLen(int'(qIdx)) - 1));
  assign lastQuery = (qIdx == QI_W'(NUM_QUERY - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      dlyCnt <= '0;
      qIdx   <= '0;
      bCnt   <= '0;
      capIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_RST_HI;
          dlyCnt <= '0;
          qIdx   <= '0;
          bCnt   <= '0;
          capIdx <= '0;
        end
        S_RST_HI, S_RST_LO, S_RST_REL: begin
          if (phaseEnd) begin
            dlyCnt <= '0;
            state  <= (state == S_RST_HI) ? S_RST_LO :
                      (state == S_RST_LO) ? S_RST_REL : S_SWR_WR;
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
          end
        end
        S_SWR_WR:  state <= S_SWR_GAP;
        S_SWR_GAP: state <= S_CMD_WR;
        S_CMD_WR:  state <= S_CMD_GAP;
        S_CMD_GAP: state <= S_RD;
        S_RD: begin
          state  <= S_RD_GAP;
          capIdx <= capIdx + 1'b1;
        end
        S_RD_GAP: begin
          if (lastByte) begin
            bCnt <= '0;
            if (lastQuery) state <= S_IDLE;
            else begin
              qIdx  <= qIdx + 1'b1;
              state <= S_CMD_WR;
            end
          end else begin
            bCnt  <= bCnt + 1'b1;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.dataSel = 1'b1;
    case (state)
      S_RST_LO:  ctl.rstLow = 1'b1;
      S_SWR_WR, S_CMD_WR: begin
        ctl.dataSel  = 1'b0;
        ctl.wrStb    = 1'b1;
        ctl.busDrive = 1'b1;
      end
      S_SWR_GAP, S_CMD_GAP: begin
        ctl.dataSel  = 1'b0;
        ctl.busDrive = 1'b1;
      end
      S_RD: begin
        ctl.rdStb   = 1'b1;
        ctl.capture = 1'b1;
      end
      S_RD_GAP:  ctl.finish = lastByte & lastQuery;
      default: ;
    endcase
    ctl.clear = (state == S_IDLE) & start;
  end

  assign wrByte = (state == S_SWR_WR || state == S_SWR_GAP) ? SOFT_RESET_CMD
                                                            : queryAddr(int'(qIdx));
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/probe_dpath.sv
module probe_dpath
  import probe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  probe_ctl_t       ctl,
  input  logic [7:0]       wrByte,
  input  logic [IDX_W-1:0] capIdx,
  inout  wire  [7:0]       dbus,
  input  logic [23:0]      sigBytes,
  input  logic [IDX_W-1:0] bufAddr,
  output logic [7:0]       bufData,
  output logic             done,
  output logic             match
);

  logic [7:0]         capBuf [NUM_BYTES];
  logic [SIG_LEN-1:0] hitA, hitB;

  assign dbus = ctl.busDrive ? wrByte : 8'hzz;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      for (int i = 0; i < NUM_BYTES; i++) capBuf[i] <= '0;
    end else if (ctl.clear) begin
      done <= 1'b0;
      for (int i = 0; i < NUM_BYTES; i++) capBuf[i] <= '0;
    end else begin
      if (ctl.capture) capBuf[capIdx] <= dbus;
      if (ctl.finish)  done <= 1'b1;
    end
  end

  for (genvar g = 0; g < SIG_LEN; g++) begin : g_sig
    assign hitA[g] = (capBuf[SIG_OFS_A + g] == sigBytes[23 - 8*g -: 8]);
    assign hitB[g] = (capBuf[SIG_OFS_B + g] == sigBytes[23 - 8*g -: 8]);
  end

  assign match = done & (&hitA) & (&hitB);

  always_comb begin
    bufData = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (bufAddr == IDX_W'(i)) bufData = capBuf[i];
  end

endmodule

// File: rtl/panel_id_probe.sv
module panel_id_probe
  import probe_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int RESET_MS   = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [23:0]      sigBytes,
  input  logic [IDX_W-1:0] bufAddr,
  output logic [7:0]       bufData,
  output logic             panelRstN,
  output logic             dcSel,
  output logic             wrN,
  output logic             rdN,
  inout  wire  [7:0]       dataBus,
  output logic             busy,
  output logic             done,
  output logic             match
);

  localparam int PHASE_CYC = CYC_PER_MS * RESET_MS;

  probe_ctl_t       ctl;
  logic [7:0]       wrByte;
  logic [IDX_W-1:0] capIdx;
  logic             busOe;

  probe_ctrl #(.PHASE_CYC(PHASE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .wrByte(wrByte), .capIdx(capIdx), .busy(busy)
  );

  probe_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrByte(wrByte), .capIdx(capIdx),
    .dbus(dataBus), .sigBytes(sigBytes), .bufAddr(bufAddr),
    .bufData(bufData), .done(done), .match(match)
  );

  assign panelRstN = ~ctl.rstLow;
  assign dcSel     = ctl.dataSel;
  assign wrN       = ~ctl.wrStb;
  assign rdN       = ~ctl.rdStb;
  assign busOe     = ctl.busDrive;

endmodule

// File: rtl/probe_chk.sv
module probe_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic match,
  input logic panelRstN,
  input logic wrN,
  input logic rdN,
  input logic dcSel,
  input logic busOe
);

  assert_rst_in_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    !panelRstN |-> busy);

  assert_cmd_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !dcSel);

  assert_data_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> dcSel);

  assert_bus_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> wrN);

  assert_wr_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |=> wrN);

  assert_rd_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |=> rdN);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_match_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    match |-> done);

endmodule

bind panel_id_probe probe_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .match(match),
  .panelRstN(panelRstN), .wrN(wrN), .rdN(rdN), .dcSel(dcSel), .busOe(busOe)
);

// File: tb/panel_id_probe_tb.sv
module panel_id_probe_tb;

  localparam int CPM        = 4;
  localparam int RMS        = 200;
  localparam int P          = CPM * RMS;
  localparam int TOTAL_BUSY = 3 * P + 70;

  logic        clk = 1'b0;
  logic        rstN, start;
  logic [23:0] sigBytes;
  logic [4:0]  bufAddr;
  logic [7:0]  bufData;
  logic        panelRstN, dcSel, wrN, rdN, busy, done, match;
  wire  [7:0]  dataBus;

  always #5 clk = ~clk;

  panel_id_probe #(.CYC_PER_MS(CPM), .RESET_MS(RMS)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .sigBytes(sigBytes),
    .bufAddr(bufAddr), .bufData(bufData), .panelRstN(panelRstN),
    .dcSel(dcSel), .wrN(wrN), .rdN(rdN), .dataBus(dataBus),
    .busy(busy), .done(done), .match(match)
  );

  int checks = 0;
  int fails  = 0;

  // ---- display controller model ----
  bit         altDev = 1'b0;
  logic       modelAwake = 1'b0;
  logic [7:0] lastCmd = 8'h00;
  int         rdIdx = 0;
  bit         rdWasLow = 1'b0, wrWasLow = 1'b0;

  function automatic logic [7:0] respByte(input logic [7:0] a, input int k);
    case (a)
      8'h04: case (k) 0, 1: return 8'h54; 2: return 8'h80; 3: return 8'h66; default: return 8'h00; endcase
      8'hDA: return 8'h54;
      8'hDB: return altDev ? 8'h81 : 8'h80;
      8'hDC: return 8'h66;
      default: return a ^ 8'(k << 4) ^ 8'h3C;
    endcase
  endfunction

  assign dataBus = (!rdN && modelAwake) ? respByte(lastCmd, rdIdx) : 8'hzz;

  // expected query list, kept independently of the design
  function automatic logic [7:0] expAddr(input int i);
    logic [7:0] t [7] = '{8'h04, 8'hA1, 8'hBF, 8'hDA, 8'hDB, 8'hDC, 8'hD3};
    return t[i];
  endfunction
  function automatic int expLen(input int i);
    int t [7] = '{6, 6, 6, 1, 1, 1, 6};
    return t[i];
  endfunction

  // ---- bus monitor ----
  bit         monClear = 1'b0;
  int         cmdCnt, busyCnt, wideStb, busFault, earlyRead, dataWr;
  logic [7:0] cmdLog [16];
  int         rdPer [16];

  always @(negedge clk) begin
    if (!panelRstN) modelAwake = 1'b0;
    if (monClear) begin
      cmdCnt = 0; busyCnt = 0; wideStb = 0; busFault = 0; earlyRead = 0; dataWr = 0;
      for (int i = 0; i < 16; i++) begin cmdLog[i] = 8'h00; rdPer[i] = 0; end
    end else begin
      if (busy) busyCnt++;
      if (!wrN) begin
        if (wrWasLow) wideStb++;
        if (dcSel) dataWr++;
        else begin
          if (cmdCnt < 16) cmdLog[cmdCnt] = dataBus;
          cmdCnt++;
        end
      end
      if (!rdN) begin
        if (rdWasLow) wideStb++;
        if (cmdCnt == 0 || cmdLog[0] != 8'h01) earlyRead++;
        if ($isunknown(dataBus)) busFault++;
        if (cmdCnt > 0 && cmdCnt <= 16) rdPer[cmdCnt-1]++;
      end
    end
    if (!wrN && !dcSel) begin
      lastCmd = dataBus;
      rdIdx   = 0;
      if (dataBus == 8'h01 && panelRstN) modelAwake = 1'b1;
    end
    if (!rdN) rdWasLow = 1'b1;
    else if (rdWasLow) begin rdIdx++; rdWasLow = 1'b0; end
    wrWasLow = !wrN;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One full probe run; returns measured reset phase lengths.
  task automatic runProbe(input bit midStart, output int hi1, output int lo, output int hi2);
    monClear = 1'b1;
    @(negedge clk);
    #1 monClear = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8", "done cleared by start", done, 0);
    hi1 = 0; lo = 0; hi2 = 0;
    while (panelRstN) begin hi1++; @(negedge clk); end
    while (!panelRstN) begin lo++; @(negedge clk); end
    while (wrN) begin hi2++; @(negedge clk); end
    chk(match == 1'b0 && busy, "R9", "match low while busy", match, 0);
    if (midStart) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkBuffer(input string tag);
    int idx;
    idx = 0;
    for (int q = 0; q < 7; q++) begin
      for (int k = 0; k < expLen(q); k++) begin
        logic [7:0] e;
        e = respByte(expAddr(q), k);
        bufAddr = 5'(idx);
        #1;
        chk(bufData == e, "R7", tag, bufData, e);
        idx++;
      end
    end
  endtask

  task automatic test_reset_state;
    chk(panelRstN == 1'b1, "R1", "panelRstN", panelRstN, 1);
    chk(wrN == 1'b1 && rdN == 1'b1, "R1", "strobes idle", {wrN, rdN}, 3);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(match == 1'b0, "R1", "match", match, 0);
  endtask

  task automatic test_known_device;
    int h1, l0, h2;
    altDev = 1'b0;
    sigBytes = 24'h548066;
    runProbe(1'b0, h1, l0, h2);
    chk(h1 == P, "R2", "first high phase", h1, P);
    chk(l0 == P, "R2", "low phase", l0, P);
    chk(h2 == P, "R2", "release phase", h2, P);
    chk(cmdLog[0] == 8'h01, "R3", "soft reset byte", cmdLog[0], 8'h01);
    chk(earlyRead == 0, "R3", "reads before soft reset", earlyRead, 0);
    chk(rdPer[0] == 0, "R3", "reads after soft reset", rdPer[0], 0);
    chk(cmdCnt == 8, "R4", "command count", cmdCnt, 8);
    for (int q = 0; q < 7; q++) begin
      chk(cmdLog[q+1] == expAddr(q), "R4", "command byte", cmdLog[q+1], expAddr(q));
      chk(rdPer[q+1] == expLen(q), "R4", "read count", rdPer[q+1], expLen(q));
    end
    chk(dataWr == 0, "R4", "data-phase writes", dataWr, 0);
    chk(busFault == 0, "R5", "bus contention during reads", busFault, 0);
    chk(wideStb == 0, "R6", "strobe wider than one cycle", wideStb, 0);
    chk(busyCnt == TOTAL_BUSY, "R8", "busy cycles", busyCnt, TOTAL_BUSY);
    chk(done == 1'b1 && busy == 1'b0, "R8", "done after run", {done, busy}, 2);
    chk(match == 1'b1, "R9", "match on known device", match, 1);
    checkBuffer("buffer known device");
  endtask

  task automatic test_sig_change;
    sigBytes = 24'h548067;
    #1;
    chk(match == 1'b0, "R9", "match with altered signature", match, 0);
    sigBytes = 24'h548066;
    #1;
    chk(match == 1'b1, "R9", "match restored", match, 1);
  endtask

  task automatic test_alt_device;
    int h1, l0, h2;
    altDev = 1'b1;
    runProbe(1'b0, h1, l0, h2);
    chk(done == 1'b1, "R8", "done alt device", done, 1);
    chk(match == 1'b0, "R9", "no match when single-byte id differs", match, 0);
    bufAddr = 5'd19;
    #1;
    chk(bufData == 8'h81, "R7", "entry 19 holds 0xDB reply", bufData, 8'h81);
  endtask

  task automatic test_start_ignored;
    int h1, l0, h2;
    altDev = 1'b0;
    runProbe(1'b1, h1, l0, h2);
    chk(busyCnt == TOTAL_BUSY, "R10", "run length with stray start", busyCnt, TOTAL_BUSY);
    chk(cmdCnt == 8, "R10", "command count with stray start", cmdCnt, 8);
    chk(match == 1'b1, "R10", "result with stray start", match, 1);
    checkBuffer("R10 buffer with stray start");
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; sigBytes = 24'h548066; bufAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset_state();
    test_known_device();
    test_sig_change();
    test_alt_device();
    test_start_ignored();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual hung expected complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end

endmodule